// File: doc/BRIEF.md
# Video Line and Frame Timing Sequencer

This block produces the timing skeleton of one video stream for a serial display link. Two position counters run side by side. One walks across a line in lane byte clock cycles. The other walks down the frame one line at a time. Each counter splits its range into four segments in a fixed order: sync, back porch, active and front porch. Software sets every segment length, the video transfer type, a low-power permission mask and the output polarities through a simple one-cycle register write port. A packet framer downstream uses the segment flags and strobes to decide what to send in each byte clock.

The horizontal front porch is not programmed. It is whatever the programmed line total leaves after sync, back porch and active time. If those three add up to more than the total, the line is stretched to fit them. A segment of length zero is skipped. The `en` input gates the whole sequence. While it is low, both counters are held at the frame origin, so the next enabled cycle starts a fresh frame.

All outputs are registered. The outputs seen after a clock edge describe the position that the counters held just before that edge.

Top module: `vid_timing_seq`

## Requirements
- R1: After a synchronous reset, every configuration register reads as zero. Every segment flag, every strobe and `lp_ok_o` is low, and `hsync_o`, `vsync_o` and `de_o` are low.
- R2: Horizontal segments follow each other as sync (length from address 0), back porch (address 1), active (bits 13:0 of address 3), then front porch. The line lasts max(total at address 2, sync+back porch+active, 1) cycles, and the front porch fills the remainder.
- R3: Vertical segments follow each other as sync (address 4), back porch (address 5), active (address 6), then front porch (address 7), in lines. The line counter advances on the cycle after the last cycle of a line. A frame lasts max(sum of the four, 1) lines.
- R4: A segment programmed to zero never appears, and the following segment starts in its place. An all-zero setup gives a one-cycle, one-line frame that is all front porch.
- R5: `sol_o` is high on the first cycle of every line. `sof_o` is high only on the first cycle of the first line of a frame, which is the first vertical sync line whenever that segment is non-zero.
- R6: Bits 1:0 of address 8 select the transfer type. Type 0 (sync pulses) raises `hss_o` on the first horizontal sync cycle and `hse_o` on the last one. Types 1 (sync events) and 2 (burst), and the spare value 3, raise only `hss_o`.
- R7: Bits 13:8 of address 8 form the low-power mask. Bits 0, 1 and 2 allow low power on whole vertical sync, back porch and front porch lines. On active lines, bits 5, 4 and 3 allow it in horizontal sync, back porch and front porch. `lp_ok_o` is never high during active pixels.
- R8: At address 9, bit 0 inverts `de_o`, bit 1 inverts `vsync_o` and bit 2 inverts `hsync_o`, each making its signal active low. Bits above 2 have no effect.
- R9: While `en` is low, the outputs one cycle later are idle: flags, strobes and `lp_ok_o` are low, and `de_o`, `hsync_o` and `vsync_o` sit at their inactive level. The first output cycle after `en` rises is the first cycle of a frame.
- R10: Writes to addresses 10 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the frame origin |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| h_sync_o | output | 1 | Horizontal sync segment |
| h_bp_o | output | 1 | Horizontal back porch segment |
| h_act_o | output | 1 | Horizontal active segment |
| h_fp_o | output | 1 | Horizontal front porch segment |
| v_sync_o | output | 1 | Vertical sync line |
| v_bp_o | output | 1 | Vertical back porch line |
| v_act_o | output | 1 | Vertical active line |
| v_fp_o | output | 1 | Vertical front porch line |
| hsync_o | output | 1 | Horizontal sync with polarity applied |
| vsync_o | output | 1 | Vertical sync with polarity applied |
| de_o | output | 1 | Data enable with polarity applied |
| sol_o | output | 1 | Start-of-line strobe |
| sof_o | output | 1 | Start-of-frame strobe |
| hss_o | output | 1 | Horizontal sync start strobe |
| hse_o | output | 1 | Horizontal sync end strobe (sync pulse type only) |
| lp_ok_o | output | 1 | Low-power transmission allowed in this cycle |

## Verification
Some rules hold on every cycle and the assertions check them there. A horizontal segment flag is never doubled. The sync-start strobe coincides with a line start inside sync. The sync-end strobe only falls inside sync. Frame start implies line start. Low power is never granted on an active pixel. A low enable idles the outputs on the next cycle. Segment lengths, the stretched line, skipped zero segments, the mask mapping, polarity and unmapped writes can only be shown by the bench's scenarios. The bench follows the line and frame position and compares every output against what the programmed values predict.

// File: rtl/vts_pkg.sv
package vts_pkg;
  localparam int CFG_AW = 4;
  localparam int CFG_DW = 32;

  // register addresses
  localparam logic [CFG_AW-1:0] A_HSA   = 4'd0;
  localparam logic [CFG_AW-1:0] A_HBP   = 4'd1;
  localparam logic [CFG_AW-1:0] A_HLINE = 4'd2;
  localparam logic [CFG_AW-1:0] A_HACT  = 4'd3;
  localparam logic [CFG_AW-1:0] A_VSA   = 4'd4;
  localparam logic [CFG_AW-1:0] A_VBP   = 4'd5;
  localparam logic [CFG_AW-1:0] A_VACT  = 4'd6;
  localparam logic [CFG_AW-1:0] A_VFP   = 4'd7;
  localparam logic [CFG_AW-1:0] A_MODE  = 4'd8;
  localparam logic [CFG_AW-1:0] A_POL   = 4'd9;

  typedef enum logic [1:0] {
    VT_PULSE = 2'd0,
    VT_EVENT = 2'd1,
    VT_BURST = 2'd2,
    VT_SPARE = 2'd3
  } vtype_e;

  // low-power mask bit positions
  localparam int LP_VSA = 0;
  localparam int LP_VBP = 1;
  localparam int LP_VFP = 2;
  localparam int LP_HFP = 3;
  localparam int LP_HBP = 4;
  localparam int LP_HSA = 5;
  localparam int LP_W   = 6;

  // polarity bit positions
  localparam int POL_DE = 0;
  localparam int POL_VS = 1;
  localparam int POL_HS = 2;
  localparam int POL_W  = 3;

  // segment indices in time order
  localparam int SEG_SYNC = 0;
  localparam int SEG_BP   = 1;
  localparam int SEG_ACT  = 2;
  localparam int SEG_FP   = 3;
  localparam int NSEG     = 4;
endpackage

// File: rtl/vts_cfg_regs.sv
module vts_cfg_regs
  import vts_pkg::*;
#(
  parameter int HW   = 16,
  parameter int VW   = 12,
  parameter int PIXW = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [HW-1:0]     hsa,
  output logic [HW-1:0]     hbp,
  output logic [HW-1:0]     hline,
  output logic [PIXW-1:0]   hact,
  output logic [VW-1:0]     vsa,
  output logic [VW-1:0]     vbp,
  output logic [VW-1:0]     vact,
  output logic [VW-1:0]     vfp,
  output vtype_e            vtype,
  output logic [LP_W-1:0]   lp_mask,
  output logic [POL_W-1:0]  pol
);
  localparam int LP_LSB = 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsa     <= '0;
      hbp     <= '0;
      hline   <= '0;
      hact    <= '0;
      vsa     <= '0;
      vbp     <= '0;
      vact    <= '0;
      vfp     <= '0;
      vtype   <= VT_PULSE;
      lp_mask <= '0;
      pol     <= '0;
    end else if (we) begin
      case (addr)
        A_HSA:   hsa   <= wdata[HW-1:0];
        A_HBP:   hbp   <= wdata[HW-1:0];
        A_HLINE: hline <= wdata[HW-1:0];
        A_HACT:  hact  <= wdata[PIXW-1:0];
        A_VSA:   vsa   <= wdata[VW-1:0];
        A_VBP:   vbp   <= wdata[VW-1:0];
        A_VACT:  vact  <= wdata[VW-1:0];
        A_VFP:   vfp   <= wdata[VW-1:0];
        A_MODE: begin
          vtype   <= vtype_e'(wdata[1:0]);
          lp_mask <= wdata[LP_LSB +: LP_W];
        end
        A_POL:   pol   <= wdata[POL_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vts_seg_ctr.sv
module vts_seg_ctr
  import vts_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 step,
  input  logic [NSEG-1:0][W-1:0] len,
  output logic [NSEG-1:0]      seg,
  output logic [W+1:0]         pos,
  output logic                 wrap
);
  localparam int SW = W + 2;

  logic [NSEG-1:0][SW-1:0] bnd;
  logic [SW-1:0]           last;

  // running segment end boundaries
  always_comb begin
    bnd[0] = SW'(len[0]);
    for (int i = 1; i < NSEG; i++) bnd[i] = bnd[i-1] + SW'(len[i]);
  end

  assign last = (bnd[NSEG-1] == '0) ? '0 : bnd[NSEG-1] - SW'(1);
  assign wrap = (pos >= last);

  // first segment whose end lies beyond pos; the last one catches the rest
  always_comb begin
    logic hit;
    seg = '0;
    hit = 1'b0;
    for (int i = 0; i < NSEG - 1; i++) begin
      if (!hit && pos < bnd[i]) begin
        seg[i] = 1'b1;
        hit    = 1'b1;
      end
    end
    if (!hit) seg[NSEG-1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  pos <= '0;
    else if (step)   pos <= wrap ? '0 : pos + SW'(1);
  end
endmodule

// File: rtl/vid_timing_seq.sv
module vid_timing_seq
  import vts_pkg::*;
#(
  parameter int HW   = 16,
  parameter int VW   = 12,
  parameter int PIXW = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              h_sync_o,
  output logic              h_bp_o,
  output logic              h_act_o,
  output logic              h_fp_o,
  output logic              v_sync_o,
  output logic              v_bp_o,
  output logic              v_act_o,
  output logic              v_fp_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              sol_o,
  output logic              sof_o,
  output logic              hss_o,
  output logic              hse_o,
  output logic              lp_ok_o
);
  localparam int HSW = HW + 2;
  localparam int VSW = VW + 2;

  logic [HW-1:0]    hsa, hbp, hline, hfp;
  logic [PIXW-1:0]  hact;
  logic [VW-1:0]    vsa, vbp, vact, vfp;
  vtype_e           vtype;
  logic [LP_W-1:0]  lp_mask;
  logic [POL_W-1:0] pol;

  vts_cfg_regs #(.HW(HW), .VW(VW), .PIXW(PIXW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .hsa(hsa), .hbp(hbp), .hline(hline), .hact(hact),
    .vsa(vsa), .vbp(vbp), .vact(vact), .vfp(vfp),
    .vtype(vtype), .lp_mask(lp_mask), .pol(pol)
  );

  // front porch takes what the line total leaves over
  logic [HSW-1:0] hused;
  assign hused = HSW'(hsa) + HSW'(hbp) + HSW'(hact);
  assign hfp   = (HSW'(hline) > hused) ? HW'(HSW'(hline) - hused) : '0;

  logic [NSEG-1:0]  hseg, vseg;
  logic [HSW-1:0]   hpos;
  logic [VSW-1:0]   vpos;
  logic             hwrap, vwrap;

  vts_seg_ctr #(.W(HW)) u_hctr (
    .clk(clk), .rst(rst), .clr(!en), .step(en),
    .len({hfp, HW'(hact), hbp, hsa}),
    .seg(hseg), .pos(hpos), .wrap(hwrap)
  );

  vts_seg_ctr #(.W(VW)) u_vctr (
    .clk(clk), .rst(rst), .clr(!en), .step(en && hwrap),
    .len({vfp, vact, vbp, vsa}),
    .seg(vseg), .pos(vpos), .wrap(vwrap)
  );

  // decode of the current position
  logic at_sol, at_sof, nx_hss, nx_hse, nx_lp;
  assign at_sol = (hpos == '0);
  assign at_sof = at_sol && (vpos == '0);
  assign nx_hss = hseg[SEG_SYNC] && at_sol;
  assign nx_hse = (vtype == VT_PULSE) && hseg[SEG_SYNC] &&
                  (hpos == HSW'(hsa) - HSW'(1));

  always_comb begin
    nx_lp = 1'b0;
    if (vseg[SEG_SYNC])     nx_lp = lp_mask[LP_VSA];
    else if (vseg[SEG_BP])  nx_lp = lp_mask[LP_VBP];
    else if (vseg[SEG_FP])  nx_lp = lp_mask[LP_VFP];
    else if (hseg[SEG_SYNC]) nx_lp = lp_mask[LP_HSA];
    else if (hseg[SEG_BP])  nx_lp = lp_mask[LP_HBP];
    else if (hseg[SEG_FP])  nx_lp = lp_mask[LP_HFP];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {h_sync_o, h_bp_o, h_act_o, h_fp_o} <= '0;
      {v_sync_o, v_bp_o, v_act_o, v_fp_o} <= '0;
      {hsync_o, vsync_o, de_o}            <= '0;
      {sol_o, sof_o, hss_o, hse_o, lp_ok_o} <= '0;
    end else if (!en) begin
      {h_sync_o, h_bp_o, h_act_o, h_fp_o} <= '0;
      {v_sync_o, v_bp_o, v_act_o, v_fp_o} <= '0;
      hsync_o <= pol[POL_HS];
      vsync_o <= pol[POL_VS];
      de_o    <= pol[POL_DE];
      {sol_o, sof_o, hss_o, hse_o, lp_ok_o} <= '0;
    end else begin
      h_sync_o <= hseg[SEG_SYNC];
      h_bp_o   <= hseg[SEG_BP];
      h_act_o  <= hseg[SEG_ACT];
      h_fp_o   <= hseg[SEG_FP];
      v_sync_o <= vseg[SEG_SYNC];
      v_bp_o   <= vseg[SEG_BP];
      v_act_o  <= vseg[SEG_ACT];
      v_fp_o   <= vseg[SEG_FP];
      hsync_o  <= hseg[SEG_SYNC] ^ pol[POL_HS];
      vsync_o  <= vseg[SEG_SYNC] ^ pol[POL_VS];
      de_o     <= (hseg[SEG_ACT] && vseg[SEG_ACT]) ^ pol[POL_DE];
      sol_o    <= at_sol;
      sof_o    <= at_sof;
      hss_o    <= nx_hss;
      hse_o    <= nx_hse;
      lp_ok_o  <= nx_lp;
    end
  end

  // R9: a low enable idles every flag and strobe one cycle later
  p_idle_after_disable_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(h_sync_o || h_bp_o || h_act_o || h_fp_o || v_sync_o || v_bp_o ||
              v_act_o || v_fp_o || sol_o || sof_o || hss_o || hse_o || lp_ok_o));

  // R2: at most one horizontal segment flag at a time
  p_one_hseg_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({h_sync_o, h_bp_o, h_act_o, h_fp_o}));

  // R5: a frame start is always a line start
  p_sof_is_sol_r5: assert property (@(posedge clk) disable iff (rst)
    sof_o |-> sol_o);

  // R6: sync start falls on a line start inside sync
  p_hss_at_line_start_r6: assert property (@(posedge clk) disable iff (rst)
    hss_o |-> (sol_o && h_sync_o));

  // R6: sync end only inside the sync segment
  p_hse_in_sync_r6: assert property (@(posedge clk) disable iff (rst)
    hse_o |-> h_sync_o);

  // R7: no low power on an active pixel
  p_no_lp_active_r7: assert property (@(posedge clk) disable iff (rst)
    lp_ok_o |-> !(h_act_o && v_act_o));
endmodule

// File: tb/vid_timing_seq_bench.sv
module vid_timing_seq_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, en, cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic h_sync_o, h_bp_o, h_act_o, h_fp_o, v_sync_o, v_bp_o, v_act_o, v_fp_o;
  logic hsync_o, vsync_o, de_o, sol_o, sof_o, hss_o, hse_o, lp_ok_o;

  vid_timing_seq u_vid_timing_seq (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata),
    .h_sync_o(h_sync_o), .h_bp_o(h_bp_o), .h_act_o(h_act_o), .h_fp_o(h_fp_o),
    .v_sync_o(v_sync_o), .v_bp_o(v_bp_o), .v_act_o(v_act_o), .v_fp_o(v_fp_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .sol_o(sol_o),
    .sof_o(sof_o), .hss_o(hss_o), .hse_o(hse_o), .lp_ok_o(lp_ok_o)
  );

  int s_hsa, s_hbp, s_hline, s_hact, s_vsa, s_vbp, s_vact, s_vfp;
  int s_mode, s_mask, s_pol;
  int h_pos, v_pos;
  int n_chk, n_bad;
  string ctx;

  function automatic int line_len();
    int u = s_hsa + s_hbp + s_hact;
    int l = (s_hline > u) ? s_hline : u;
    return (l < 1) ? 1 : l;
  endfunction

  function automatic int frame_len();
    int f = s_vsa + s_vbp + s_vact + s_vfp;
    return (f < 1) ? 1 : f;
  endfunction

  function automatic logic [15:0] idle_vec();
    logic [15:0] e = '0;
    e[7] = s_pol[2]; e[6] = s_pol[1]; e[5] = s_pol[0];
    return e;
  endfunction

  function automatic logic [15:0] expect_vec(int h, int v);
    logic [15:0] e;
    logic hs, hb, ha, hf, vs, vb, va, vf, lp;
    hs = (h < s_hsa);
    hb = !hs && (h < s_hsa + s_hbp);
    ha = !hs && !hb && (h < s_hsa + s_hbp + s_hact);
    hf = !hs && !hb && !ha;
    vs = (v < s_vsa);
    vb = !vs && (v < s_vsa + s_vbp);
    va = !vs && !vb && (v < s_vsa + s_vbp + s_vact);
    vf = !vs && !vb && !va;
    if (vs)      lp = s_mask[0];
    else if (vb) lp = s_mask[1];
    else if (vf) lp = s_mask[2];
    else if (hs) lp = s_mask[5];
    else if (hb) lp = s_mask[4];
    else if (hf) lp = s_mask[3];
    else         lp = 1'b0;
    e = {hs, hb, ha, hf, vs, vb, va, vf,
         hs ^ s_pol[2], vs ^ s_pol[1], (ha && va) ^ s_pol[0],
         (h == 0), (h == 0 && v == 0), (hs && h == 0),
         (s_mode == 0 && hs && h == s_hsa - 1), lp};
    return e;
  endfunction

  task automatic compare(logic [15:0] e);
    logic [15:0] a;
    logic [15:0] masks [6];
    string tags [6];
    a = {h_sync_o, h_bp_o, h_act_o, h_fp_o, v_sync_o, v_bp_o, v_act_o, v_fp_o,
         hsync_o, vsync_o, de_o, sol_o, sof_o, hss_o, hse_o, lp_ok_o};
    masks = '{16'hF000, 16'h0F00, 16'h00E0, 16'h0018, 16'h0006, 16'h0001};
    tags  = '{"R2", "R3", "R8", "R5", "R6", "R7"};
    for (int g = 0; g < 6; g++) begin
      n_chk++;
      if ((a & masks[g]) !== (e & masks[g])) begin
        n_bad++;
        $display("FAIL %s [%s] h=%0d v=%0d actual %b expected %b",
                 tags[g], ctx, h_pos, v_pos, a & masks[g], e & masks[g]);
      end
    end
  endtask

  task automatic step();
    logic [15:0] e;
    logic run;
    run = en && !rst;
    e = run ? expect_vec(h_pos, v_pos) : (rst ? 16'h0 : idle_vec());
    @(posedge clk);
    #1;
    compare(e);
    if (run) begin
      h_pos++;
      if (h_pos >= line_len()) begin
        h_pos = 0;
        v_pos++;
        if (v_pos >= frame_len()) v_pos = 0;
      end
    end else begin
      h_pos = 0;
      v_pos = 0;
    end
  endtask

  task automatic run_n(int n);
    repeat (n) step();
  endtask

  task automatic set_en(logic b);
    @(negedge clk);
    en = b;
  endtask

  task automatic cfg_write(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 32'(d);
    step();
    cfg_we = 1'b0;
    case (a)
      0: s_hsa   = d & 16'hFFFF;
      1: s_hbp   = d & 16'hFFFF;
      2: s_hline = d & 16'hFFFF;
      3: s_hact  = d & 16'h3FFF;
      4: s_vsa   = d & 12'hFFF;
      5: s_vbp   = d & 12'hFFF;
      6: s_vact  = d & 12'hFFF;
      7: s_vfp   = d & 12'hFFF;
      8: begin s_mode = d & 3; s_mask = (d >> 8) & 63; end
      9: s_pol = d & 7;
      default: ;
    endcase
  endtask

  task automatic load(int hsa, int hbp, int hact, int hline, int vsa, int vbp,
                      int vact, int vfp, int mode, int mask, int pol);
    cfg_write(0, hsa);  cfg_write(1, hbp);  cfg_write(3, hact);
    cfg_write(2, hline); cfg_write(4, vsa); cfg_write(5, vbp);
    cfg_write(6, vact); cfg_write(7, vfp);
    cfg_write(8, (mask << 8) | mode); cfg_write(9, pol);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hl;
    n_chk = 0; n_bad = 0;
    s_hsa = 0; s_hbp = 0; s_hline = 0; s_hact = 0;
    s_vsa = 0; s_vbp = 0; s_vact = 0; s_vfp = 0;
    s_mode = 0; s_mask = 0; s_pol = 0;
    h_pos = 0; v_pos = 0;
    rst = 1'b1; en = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    void'($urandom(32'd2024));

    ctx = "R1 reset state";
    run_n(3);
    @(negedge clk); rst = 1'b0;
    run_n(2);

    ctx = "R4 all-zero one-cycle frame";
    set_en(1'b1);
    run_n(6);

    ctx = "R6 sync pulse type, R7 mask";
    set_en(1'b0); run_n(1);
    load(2, 3, 4, 12, 1, 1, 2, 1, 0, 6'b101010, 0);
    set_en(1'b1);
    run_n(130);

    ctx = "R4 zero sync/bp, line stretched";
    set_en(1'b0); run_n(1);
    load(0, 0, 5, 3, 0, 2, 1, 0, 1, 6'b010101, 3'b111);
    set_en(1'b1);
    run_n(40);

    ctx = "R10 unmapped writes, R8 high bits";
    cfg_write(12, 32'hFFFF_FFFF);
    cfg_write(15, 32'h0000_3F03);
    run_n(10);
    set_en(1'b0); run_n(1);
    cfg_write(9, 32'hFFFF_FFF8);
    run_n(3);

    ctx = "R9 enable toggled mid-frame";
    load(1, 2, 3, 9, 2, 1, 3, 1, 2, 6'b111111, 3'b010);
    set_en(1'b1); run_n(17);
    set_en(1'b0); run_n(3);
    set_en(1'b1); run_n(40);

    ctx = "random";
    for (int k = 0; k < 25; k++) begin
      set_en(1'b0); run_n(1);
      load($urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 6),
           $urandom_range(0, 20), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 63), $urandom_range(0, 7));
      set_en(1'b1);
      hl = line_len() * frame_len();
      run_n(2 * hl + 3);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule